// File: doc/BRIEF.md
# Interrupt Controller with Sleep Wake-up

This block gathers four interrupt sources for a small processor core: an external pin that fires on a selectable edge, a timer overflow pulse, a change detector on a group of input port pins, and a pulse that marks the end of a non-volatile data write. Each source owns a flag bit and an enable bit. One global enable gates the branch-to-vector request that goes to the core.

Flags latch whether or not their source is enabled, and only software clears them. While the core sleeps, any enabled and flagged source raises a wake request, whatever the global enable holds. The global enable then decides only whether the core vectors after waking or simply carries on.

When the core accepts the vector, the block saves the return PC in a single register and clears the global enable, so that a second interrupt cannot nest. A return-from-interrupt strobe sets the global enable again, and the saved PC stays readable on a port.

Top module: `intr_wake_ctrl`

## Requirements
- R1: While reset is held, the flags, the enables and the global enable are 0, the edge select is 1 (rising), the saved PC is 0, and both the vector request and the wake request are low.
- R2: The external pin passes through a two-flop synchroniser. With edge select 1 a rising edge sets flag bit 0; with edge select 0 a falling edge sets it. The flag shows after the third rising clock edge that follows the pin change. The opposite edge leaves the flag clear.
- R3: A change on any bit of the port input group sets flag bit 2 after the third rising clock edge that follows the change. That input is synchronised the same way as the external pin.
- R4: A one-cycle timer overflow pulse sets flag bit 1 at the next clock edge. A one-cycle write-done pulse sets flag bit 3 at the next clock edge.
- R5: A flag is set by its event whatever its enable bit and the global enable hold.
- R6: Hardware never clears a flag. A software write to the flag register (select 0) replaces the flags, but an event in the same cycle still sets its own bit.
- R7: The vector request is high exactly when the global enable is 1 and at least one flag has its enable bit set.
- R8: The wake request is high exactly when the sleep input is high and at least one flag has its enable bit set, whatever the global enable holds.
- R9: A vector-accept strobe stores the core PC into the saved-PC output and clears the global enable at the next clock edge.
- R10: A return strobe sets the global enable at the next clock edge. If a vector-accept strobe arrives in the same cycle, the accept wins and the global enable ends at 0.
- R11: A software write with select 1 loads the enable bits from data bits 3:0. A write with select 2 loads the global enable from data bit 0 and the edge select from data bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| port_in | input | 4 | Port pins watched for change, asynchronous |
| tmr_ovf | input | 1 | Timer overflow pulse |
| wr_done | input | 1 | Data write complete pulse |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 2 | Register select: 0 flags, 1 enables, 2 control |
| sw_wdata | input | 8 | Software write data |
| sleeping | input | 1 | Core is in sleep |
| core_pc | input | 13 | PC to save when the vector is accepted |
| vec_ack | input | 1 | Core accepts the vector |
| reti | input | 1 | Return-from-interrupt strobe |
| flags_o | output | 4 | Flags: bit 0 external, 1 timer, 2 port change, 3 write done |
| enables_o | output | 4 | Enable bits, same order as the flags |
| gie_o | output | 1 | Global enable |
| edge_rise_o | output | 1 | External edge select, 1 for rising |
| vec_req | output | 1 | Branch-to-vector request |
| wake_req | output | 1 | Wake request to the sleeping core |
| ret_pc | output | 13 | Saved return PC |

## Verification
The synchronised sources set their flags after the third rising edge that follows a pin change. The bench therefore samples once after the second edge, where the flag must still be clear, and again after the third, where it must be set. Timer and write-done pulses, software writes, and the accept and return strobes all act at the first edge. Their effects are checked at the falling edge that follows. The vector and wake requests are combinational on the flag state, so they are checked in the same half-cycle as the flags.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int NSRC = 4;
  localparam int SRC_EXT = 0;
  localparam int SRC_TMR = 1;
  localparam int SRC_CHG = 2;
  localparam int SRC_WR  = 3;

  typedef enum logic [1:0] {
    SEL_FLAGS = 2'd0,
    SEL_EN    = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } sw_sel_e;

  function automatic logic edge_hit(input logic cur, input logic prev, input logic rise);
    return rise ? (cur & ~prev) : (~cur & prev);
  endfunction

  function automatic logic any_pending(input logic [NSRC-1:0] fl, input logic [NSRC-1:0] en);
    return |(fl & en);
  endfunction
endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/intr_event_det.sv
module intr_event_det
  import intr_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_s,
  input  logic [PW-1:0] port_s,
  input  logic          edge_rise,
  output logic          ext_evt,
  output logic          chg_evt
);
  logic          ext_prev;
  logic [PW-1:0] port_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_prev  <= 1'b0;
      port_prev <= '0;
    end else begin
      ext_prev  <= ext_s;
      port_prev <= port_s;
    end
  end

  assign ext_evt = edge_hit(ext_s, ext_prev, edge_rise);
  assign chg_evt = |(port_s ^ port_prev);
endmodule

// File: rtl/intr_flag_bank.sv
module intr_flag_bank
  import intr_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         wr_flags,
  input  logic         wr_en,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] flags,
  output logic [N-1:0] enables
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          flags[i]   <= 1'b0;
          enables[i] <= 1'b0;
        end else begin
          flags[i] <= (wr_flags ? wdata[i] : flags[i]) | evt[i];
          if (wr_en) enables[i] <= wdata[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/intr_gate.sv
module intr_gate
  import intr_pkg::*;
#(
  parameter int N    = NSRC,
  parameter int PC_W = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    flags,
  input  logic [N-1:0]    enables,
  input  logic            wr_ctrl,
  input  logic            wd_gie,
  input  logic            wd_edge,
  input  logic            sleeping,
  input  logic [PC_W-1:0] core_pc,
  input  logic            vec_ack,
  input  logic            reti,
  output logic            gie,
  output logic            edge_rise,
  output logic            vec_req,
  output logic            wake_req,
  output logic [PC_W-1:0] ret_pc
);
  logic pend;
  assign pend = any_pending(flags, enables);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie       <= 1'b0;
      edge_rise <= 1'b1;
      ret_pc    <= '0;
    end else begin
      if (wr_ctrl) begin
        gie       <= wd_gie;
        edge_rise <= wd_edge;
      end
      if (reti) gie <= 1'b1;
      if (vec_ack) begin
        gie    <= 1'b0;
        ret_pc <= core_pc;
      end
    end
  end

  assign vec_req  = gie & pend;
  assign wake_req = sleeping & pend;
endmodule

// File: rtl/intr_wake_ctrl.sv
module intr_wake_ctrl
  import intr_pkg::*;
#(
  parameter int PW   = 4,
  parameter int PC_W = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_pin,
  input  logic [PW-1:0]   port_in,
  input  logic            tmr_ovf,
  input  logic            wr_done,
  input  logic            sw_we,
  input  logic [1:0]      sw_sel,
  input  logic [7:0]      sw_wdata,
  input  logic            sleeping,
  input  logic [PC_W-1:0] core_pc,
  input  logic            vec_ack,
  input  logic            reti,
  output logic [NSRC-1:0] flags_o,
  output logic [NSRC-1:0] enables_o,
  output logic            gie_o,
  output logic            edge_rise_o,
  output logic            vec_req,
  output logic            wake_req,
  output logic [PC_W-1:0] ret_pc
);
  localparam int SW = PW + 1;

  logic [SW-1:0]   sync_q;
  logic            ext_evt;
  logic            chg_evt;
  logic [NSRC-1:0] evt;
  logic            wr_flags, wr_en, wr_ctrl;

  intr_sync #(.W(SW)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({port_in, ext_pin}), .q(sync_q)
  );

  intr_event_det #(.PW(PW)) u_det (
    .clk(clk), .rst_n(rst_n),
    .ext_s(sync_q[0]), .port_s(sync_q[SW-1:1]),
    .edge_rise(edge_rise_o),
    .ext_evt(ext_evt), .chg_evt(chg_evt)
  );

  always_comb begin
    evt          = '0;
    evt[SRC_EXT] = ext_evt;
    evt[SRC_TMR] = tmr_ovf;
    evt[SRC_CHG] = chg_evt;
    evt[SRC_WR]  = wr_done;
  end

  assign wr_flags = sw_we && (sw_sel == SEL_FLAGS);
  assign wr_en    = sw_we && (sw_sel == SEL_EN);
  assign wr_ctrl  = sw_we && (sw_sel == SEL_CTRL);

  intr_flag_bank #(.N(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .wr_flags(wr_flags), .wr_en(wr_en), .wdata(sw_wdata[NSRC-1:0]),
    .flags(flags_o), .enables(enables_o)
  );

  intr_gate #(.N(NSRC), .PC_W(PC_W)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .flags(flags_o), .enables(enables_o),
    .wr_ctrl(wr_ctrl), .wd_gie(sw_wdata[0]), .wd_edge(sw_wdata[1]),
    .sleeping(sleeping), .core_pc(core_pc),
    .vec_ack(vec_ack), .reti(reti),
    .gie(gie_o), .edge_rise(edge_rise_o),
    .vec_req(vec_req), .wake_req(wake_req), .ret_pc(ret_pc)
  );
endmodule

// File: rtl/intr_wake_ctrl_chk.sv
module intr_wake_ctrl_chk #(
  parameter int PC_W = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      flags_o,
  input logic            gie_o,
  input logic            vec_req,
  input logic            wake_req,
  input logic            sleeping,
  input logic            tmr_ovf,
  input logic            wr_done,
  input logic            ext_evt,
  input logic            chg_evt,
  input logic            sw_we,
  input logic [1:0]      sw_sel,
  input logic            vec_ack,
  input logic            reti,
  input logic [PC_W-1:0] core_pc,
  input logic [PC_W-1:0] ret_pc
);
  // R7
  vec_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> gie_o);
  // R8
  wake_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> sleeping);
  // R4
  tmr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> flags_o[1]);
  // R4
  wr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> flags_o[3]);
  // R2
  ext_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt |=> flags_o[0]);
  // R3
  chg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_evt |=> flags_o[2]);
  // R6
  flag_clear_sw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flags_o) & ~flags_o)) |-> $past(sw_we && sw_sel == 2'd0));
  // R9
  ack_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack |=> (!gie_o && ret_pc == $past(core_pc)));
  // R10
  reti_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !vec_ack) |=> gie_o);
endmodule

bind intr_wake_ctrl intr_wake_ctrl_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flags_o(flags_o), .gie_o(gie_o),
  .vec_req(vec_req), .wake_req(wake_req), .sleeping(sleeping),
  .tmr_ovf(tmr_ovf), .wr_done(wr_done), .ext_evt(ext_evt), .chg_evt(chg_evt),
  .sw_we(sw_we), .sw_sel(sw_sel), .vec_ack(vec_ack), .reti(reti),
  .core_pc(core_pc), .ret_pc(ret_pc)
);

// File: tb/test_intr_wake_ctrl.sv
module test_intr_wake_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_pin = 1'b0;
  logic [3:0]  port_in = '0;
  logic        tmr_ovf = 1'b0, wr_done = 1'b0;
  logic        sw_we = 1'b0;
  logic [1:0]  sw_sel = '0;
  logic [7:0]  sw_wdata = '0;
  logic        sleeping = 1'b0;
  logic [12:0] core_pc = '0;
  logic        vec_ack = 1'b0, reti = 1'b0;
  logic [3:0]  flags_o, enables_o;
  logic        gie_o, edge_rise_o, vec_req, wake_req;
  logic [12:0] ret_pc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  intr_wake_ctrl i_intr_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_in(port_in),
    .tmr_ovf(tmr_ovf), .wr_done(wr_done), .sw_we(sw_we), .sw_sel(sw_sel),
    .sw_wdata(sw_wdata), .sleeping(sleeping), .core_pc(core_pc),
    .vec_ack(vec_ack), .reti(reti), .flags_o(flags_o), .enables_o(enables_o),
    .gie_o(gie_o), .edge_rise_o(edge_rise_o), .vec_req(vec_req),
    .wake_req(wake_req), .ret_pc(ret_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic sw_write(input logic [1:0] sel, input logic [7:0] data);
    sw_we = 1'b1; sw_sel = sel; sw_wdata = data;
    tick();
    sw_we = 1'b0; sw_sel = 2'd3;
  endtask

  // {en[3:0], gie, sleep, tmr, wr, exp_flags[3:0], exp_vec, exp_wake}
  typedef logic [13:0] vec_t;
  localparam vec_t TABLE [6] = '{
    {4'b0000, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0010, 1'b0, 1'b0},
    {4'b0010, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0010, 1'b1, 1'b0},
    {4'b0010, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0010, 1'b0, 1'b1},
    {4'b1000, 1'b1, 1'b1, 1'b0, 1'b1, 4'b1000, 1'b1, 1'b1},
    {4'b1000, 1'b1, 1'b1, 1'b1, 1'b0, 4'b0010, 1'b0, 1'b0},
    {4'b1010, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1010, 1'b0, 1'b0}
  };

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    sw_sel = 2'd3;
    tick(3);
    // R1 reset state
    chk("R1 flags", flags_o, 0);
    chk("R1 enables", enables_o, 0);
    chk("R1 gie", gie_o, 0);
    chk("R1 edge", edge_rise_o, 1);
    chk("R1 retpc", ret_pc, 0);
    chk("R1 req", {vec_req, wake_req}, 0);
    rst_n = 1'b1;
    tick(2);

    // Table: R4 R5 R7 R8 R11
    foreach (TABLE[i]) begin
      sw_write(2'd0, 8'h00);
      sw_write(2'd1, {4'b0, TABLE[i][13:10]});
      sw_write(2'd2, {6'b0, 1'b1, TABLE[i][9]});
      chk("R11 enables", enables_o, TABLE[i][13:10]);
      chk("R11 gie", gie_o, TABLE[i][9]);
      sleeping = TABLE[i][8];
      tmr_ovf = TABLE[i][7]; wr_done = TABLE[i][6];
      tick();
      tmr_ovf = 1'b0; wr_done = 1'b0;
      chk("R4 R5 flags", flags_o, TABLE[i][5:2]);
      chk("R7 vec_req", vec_req, TABLE[i][1]);
      chk("R8 wake_req", wake_req, TABLE[i][0]);
    end
    sleeping = 1'b0;

    // R6 flags persist; same-cycle clear and event
    sw_write(2'd1, 8'h00);
    tick(5);
    chk("R6 persist", flags_o, 4'b1010);
    sw_we = 1'b1; sw_sel = 2'd0; sw_wdata = 8'h00; tmr_ovf = 1'b1;
    tick();
    sw_we = 1'b0; sw_sel = 2'd3; tmr_ovf = 1'b0;
    chk("R6 event beats clear", flags_o, 4'b0010);
    sw_write(2'd0, 8'h00);
    chk("R6 sw clear", flags_o, 0);

    // R2 rising edge with select 1
    sw_write(2'd2, 8'h02);
    ext_pin = 1'b1;
    tick(2);
    chk("R2 rise early", flags_o[0], 0);
    tick();
    chk("R2 rise set", flags_o[0], 1);
    sw_write(2'd0, 8'h00);
    ext_pin = 1'b0;
    tick(4);
    chk("R2 falling ignored", flags_o[0], 0);
    // R2 falling edge with select 0
    sw_write(2'd2, 8'h00);
    ext_pin = 1'b1;
    tick(4);
    chk("R2 rising ignored", flags_o[0], 0);
    ext_pin = 1'b0;
    tick(2);
    chk("R2 fall early", flags_o[0], 0);
    tick();
    chk("R2 fall set", flags_o[0], 1);
    sw_write(2'd0, 8'h00);

    // R3 port change
    port_in = 4'b0100;
    tick(2);
    chk("R3 early", flags_o[2], 0);
    tick();
    chk("R3 set", flags_o, 4'b0100);
    sw_write(2'd0, 8'h00);
    port_in = 4'b0000;
    tick(3);
    chk("R3 back change", flags_o[2], 1);

    // R9 R10 vector accept and return
    sw_write(2'd1, 8'h04);
    sw_write(2'd2, 8'h03);
    chk("R7 pending vec", vec_req, 1);
    core_pc = 13'h123; vec_ack = 1'b1;
    tick();
    vec_ack = 1'b0;
    chk("R9 gie cleared", gie_o, 0);
    chk("R9 saved pc", ret_pc, 13'h123);
    chk("R9 vec dropped", vec_req, 0);
    reti = 1'b1;
    tick();
    reti = 1'b0;
    chk("R10 gie set", gie_o, 1);
    chk("R10 retpc held", ret_pc, 13'h123);
    core_pc = 13'h0AB; reti = 1'b1; vec_ack = 1'b1;
    tick();
    reti = 1'b0; vec_ack = 1'b0;
    chk("R10 ack wins", gie_o, 0);
    chk("R9 second pc", ret_pc, 13'h0AB);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule